// File: doc/BRIEF.md
# Tone-Pair Guard-Time Steering Controller

This block is a clocked replacement for the resistor-capacitor timing network that validates a dual-tone digit. A tone classifier upstream supplies an early-steering level and a 4-bit digit code. The early-steering level is high while a valid tone pair is heard. The controller counts ticks of a slow timebase, typically 1 kHz, so that both edges of each digit are timed. A tone must stay present for a programmable number of ticks before its code is stored. A gap must then stay open for a second programmable number of ticks before the digit is treated as finished. Because of this second count, a short dropout in the middle of a digit does not split it into two digits.

When a digit is accepted, its code is stored in a receive data register and a guard output goes high. After a programmable settling count, a data-valid flag is raised. Software reads the flag in a two-bit status word. In interrupt mode, the flag rising also sets an interrupt that pulls an active-low line. A read strobe on the receive data register clears the interrupt but leaves the flag alone. The flag drops only after the gap has been validated. Total recognition time is the classifier's detect time plus the present guard count. Interdigit time is the classifier's release time plus the absent guard count.

The controller uses six states:
- `ST_IDLE`: no digit in progress.
- `ST_PRESENT_WAIT`: timing the present guard.
- `ST_LATCHED`: a one-cycle capture state.
- `ST_SETTLE`: timing the settle count.
- `ST_ACTIVE`: the flag is up.
- `ST_ABSENT_WAIT`: timing the absent guard.

The transitions are:
- idle→present-wait when early steering rises.
- present-wait→idle when early steering falls before the guard count completes.
- present-wait→latched when the guard count completes.
- latched→settle, always.
- settle→active when the settle count completes.
- active→absent-wait when early steering falls.
- absent-wait→active when early steering returns before the count ends. The code is not captured again.
- absent-wait→idle when the absent count completes.

Top module: `tone_steer_ctrl`

## Requirements
- R1: A code is captured only when `tone_early` stays high in `ST_PRESENT_WAIT` until at least `guard_on_ticks` ticks have been counted there. If it falls earlier, the attempt is dropped: `rd_data` keeps its old value and `dv_flag` stays 0.
- R2: `rd_data` takes the value of `code_in` one cycle after the capture decision. It changes at no other time.
- R3: `guard_out` is 1 only from capture onward, while `tone_early` is high and the digit has not yet entered `ST_ABSENT_WAIT`. It is 0 in the cycle after `tone_early` is seen low in `ST_ACTIVE`.
- R4: `dv_flag` rises only when `settle_ticks` ticks have been counted after capture. It is 0 during the settle count.
- R5: `status[0]` mirrors `dv_flag`, and `status[1]` is the interrupt-pending bit. When `irq_mode`=1 and the flag rises, pending is set and `irq_n` goes 0. A one-cycle `rd_stb` clears pending and releases `irq_n`, and `dv_flag` stays 1.
- R6: When `tone_early` is low for at least `guard_off_ticks` ticks, the digit ends: `dv_flag`, pending and `irq_n`'s low level all clear. A gap that returns to high earlier resumes `ST_ACTIVE` with the flag kept and no new capture, even if `code_in` has changed.
- R7: With `irq_mode`=0, `irq_n` stays 1 and `status[1]` stays 0 through a whole digit.
- R8: After reset, `rd_data`=0, `status`=0, `dv_flag`=0, `guard_out`=0 and `irq_n`=1. With all three counts at zero, a digit is still captured, flagged and ended through the full state sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse of the guard timebase |
| tone_early | input | 1 | Early-steering level from the tone classifier |
| code_in | input | 4 | Digit code from the classifier |
| guard_on_ticks | input | 16 | Present guard length in ticks |
| guard_off_ticks | input | 16 | Absent guard length in ticks |
| settle_ticks | input | 16 | Delay from capture to flag, in ticks |
| irq_mode | input | 1 | 1 selects interrupt mode |
| rd_stb | input | 1 | Read strobe of the receive data register |
| rd_data | output | 4 | Receive data register |
| status | output | 2 | Bit 0 data-valid flag, bit 1 interrupt pending |
| guard_out | output | 1 | Guard output, high from capture while tone persists |
| dv_flag | output | 1 | Delayed data-valid flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest situation to reach is a dropout inside an accepted digit. It must be long enough to reach `ST_ABSENT_WAIT` but shorter than the absent guard. While it lasts, the classifier's code changes, which tests that the return to `ST_ACTIVE` does not capture again. Randomly drawn trials hold the tone long enough to pass both the present guard and the settle count. They then open a gap of one tick up to two ticks less than the absent guard, put a different code on `code_in`, and raise the tone again. Tone and gap lengths are kept at least one tick away from each threshold, so the tick phase cannot make the expected result ambiguous.

// File: rtl/tone_steer_pkg.sv
package tone_steer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRESENT_WAIT,
        ST_LATCHED,
        ST_SETTLE,
        ST_ACTIVE,
        ST_ABSENT_WAIT
    } steer_state_e;

endpackage

// File: rtl/steer_tick_count.sv
module steer_tick_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    // Counts timebase ticks since the last clear and saturates at the top.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/steer_out_regs.sv
module steer_out_regs #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_en,
    input  logic [CODE_W-1:0] code_in,
    input  logic              flag_set,
    input  logic              flag_clr,
    input  logic              rd_stb,
    input  logic              irq_mode,
    output logic [CODE_W-1:0] rx_code,
    output logic              dv_q,
    output logic              irq_pend
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_code  <= '0;
            dv_q     <= 1'b0;
            irq_pend <= 1'b0;
        end else begin
            if (latch_en) begin
                rx_code <= code_in;
            end
            if (flag_set) begin
                dv_q <= 1'b1;
            end else if (flag_clr) begin
                dv_q <= 1'b0;
            end
            if (flag_set && irq_mode) begin
                irq_pend <= 1'b1;
            end else if (flag_clr || rd_stb) begin
                irq_pend <= 1'b0;
            end
        end
    end

    // An interrupt may only be pending while a digit is flagged.
    p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend |-> dv_q)
        else $error("interrupt pending without data-valid flag");

endmodule

// File: rtl/tone_steer_ctrl.sv
module tone_steer_ctrl
    import tone_steer_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tone_early,
    input  logic [CODE_W-1:0] code_in,
    input  logic [TIME_W-1:0] guard_on_ticks,
    input  logic [TIME_W-1:0] guard_off_ticks,
    input  logic [TIME_W-1:0] settle_ticks,
    input  logic              irq_mode,
    input  logic              rd_stb,
    output logic [CODE_W-1:0] rd_data,
    output logic [1:0]        status,
    output logic              guard_out,
    output logic              dv_flag,
    output logic              irq_n
);

    steer_state_e      st, nxt;
    logic [TIME_W-1:0] cnt;
    logic              cnt_clr;
    logic              latch_en;
    logic              flag_set;
    logic              flag_clr;
    logic              irq_pend;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (tone_early) nxt = ST_PRESENT_WAIT;
            end
            ST_PRESENT_WAIT: begin
                if (!tone_early)                nxt = ST_IDLE;
                else if (cnt >= guard_on_ticks) nxt = ST_LATCHED;
            end
            ST_LATCHED: begin
                nxt = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (cnt >= settle_ticks) nxt = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (!tone_early) nxt = ST_ABSENT_WAIT;
            end
            ST_ABSENT_WAIT: begin
                if (tone_early)                  nxt = ST_ACTIVE;
                else if (cnt >= guard_off_ticks) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Output and strobe decode
    always_comb begin
        cnt_clr   = (nxt != st);
        latch_en  = (st == ST_PRESENT_WAIT) && (nxt == ST_LATCHED);
        flag_set  = (st == ST_SETTLE)       && (nxt == ST_ACTIVE);
        flag_clr  = (st == ST_ABSENT_WAIT)  && (nxt == ST_IDLE);
        guard_out = tone_early &&
                    (st == ST_LATCHED || st == ST_SETTLE || st == ST_ACTIVE);
    end

    steer_tick_count #(.W(TIME_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .tick  (tick),
        .cnt   (cnt)
    );

    steer_out_regs #(.CODE_W(CODE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_en (latch_en),
        .code_in  (code_in),
        .flag_set (flag_set),
        .flag_clr (flag_clr),
        .rd_stb   (rd_stb),
        .irq_mode (irq_mode),
        .rx_code  (rd_data),
        .dv_q     (dv_flag),
        .irq_pend (irq_pend)
    );

    assign status = {irq_pend, dv_flag};
    assign irq_n  = ~irq_pend;

    // Capture is only reached while the tone is still present.
    p_latch_needs_tone_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LATCHED) |-> $past(tone_early))
        else $error("capture without tone held");

    // The receive register only moves as the capture state is entered.
    p_code_moves_on_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> (st == ST_LATCHED))
        else $error("receive register changed outside capture");

    // Guard output drops once the tone loss is seen in the active state.
    p_guard_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACTIVE && !tone_early) |=> !guard_out)
        else $error("guard output held after tone loss");

    // The flag rises only at the end of the settle count.
    p_flag_after_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dv_flag) |-> $past(st == ST_SETTLE))
        else $error("flag rose outside settle exit");

    // The flag falls only at the end of a silent gap.
    p_flag_fall_in_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dv_flag) |-> !$past(tone_early))
        else $error("flag cleared while tone present");

endmodule

// File: tb/sim_tone_steer_ctrl.sv
module sim_tone_steer_ctrl;

    localparam int TDIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        tone_early = 1'b0;
    logic [3:0]  code_in = '0;
    logic [15:0] guard_on_ticks = '0;
    logic [15:0] guard_off_ticks = '0;
    logic [15:0] settle_ticks = '0;
    logic        irq_mode = 1'b0;
    logic        rd_stb = 1'b0;
    logic [3:0]  rd_data;
    logic [1:0]  status;
    logic        guard_out;
    logic        dv_flag;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    int tdiv = 0;
    logic [3:0] prev_code = '0;

    always #4 clk = ~clk;

    tone_steer_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tone_early(tone_early),
        .code_in(code_in), .guard_on_ticks(guard_on_ticks),
        .guard_off_ticks(guard_off_ticks), .settle_ticks(settle_ticks),
        .irq_mode(irq_mode), .rd_stb(rd_stb), .rd_data(rd_data),
        .status(status), .guard_out(guard_out), .dv_flag(dv_flag), .irq_n(irq_n)
    );

    // Timebase: one tick every TDIV cycles, driven away from the active edge.
    always @(negedge clk) begin
        if (tdiv == TDIV - 1) begin
            tdiv = 0;
            tick = 1'b1;
        end else begin
            tdiv = tdiv + 1;
            tick = 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic hold(input logic lvl, input int n_ticks);
        tone_early = lvl;
        repeat (n_ticks * TDIV) @(negedge clk);
    endtask

    // Tone held for n ticks is surely captured once it spans guard+2 ticks,
    // and surely dropped when it spans fewer ticks than the guard.
    function automatic bit exp_captured(input int held, input int g);
        return held >= g + 2;
    endfunction

    function automatic int exp_status(input bit flag, input bit pend);
        return (int'(pend) << 1) | int'(flag);
    endfunction

    task automatic trial(input int g, input int s, input int a, input bit im,
                         input bit longp, input bit do_drop, input bit do_read,
                         input logic [3:0] c);
        int  held;
        bit  cap;
        bit  pend;
        guard_on_ticks  = 16'(g);
        settle_ticks    = 16'(s);
        guard_off_ticks = 16'(a);
        irq_mode        = im;
        code_in         = c;
        held = longp ? g + s + 4 : g - 1;
        cap  = exp_captured(held, g);
        hold(1'b1, held);
        if (cap) begin
            pend = im;
            chk("R2", "rd_data after capture", rd_data, c);
            chk("R3", "guard_out while tone held", guard_out, 1);
            chk("R4", "dv_flag after settle", dv_flag, 1);
            chk("R5", "status with flag", status, exp_status(1'b1, pend));
            chk(im ? "R5" : "R7", "irq_n with flag", irq_n, im ? 0 : 1);
            if (do_read) begin
                rd_stb = 1'b1;
                @(negedge clk);
                rd_stb = 1'b0;
                @(negedge clk);
                pend = 1'b0;
                chk("R5", "irq_n after read", irq_n, 1);
                chk("R5", "dv_flag after read", dv_flag, 1);
                chk("R5", "status after read", status, exp_status(1'b1, 1'b0));
            end
            if (do_drop && a >= 3) begin
                int d;
                d = 1 + int'($urandom % 32'(a - 2));
                code_in = ~c;
                hold(1'b0, d);
                hold(1'b1, 2);
                chk("R6", "dv_flag across dropout", dv_flag, 1);
                chk("R6", "rd_data kept across dropout", rd_data, c);
                chk("R3", "guard_out after dropout return", guard_out, 1);
                chk("R6", "irq_n across dropout", irq_n, pend ? 0 : 1);
                code_in = c;
            end
        end
        hold(1'b0, a + 3);
        chk("R6", "dv_flag after gap", dv_flag, 0);
        chk("R6", "irq_n after gap", irq_n, 1);
        chk("R3", "guard_out after gap", guard_out, 0);
        chk("R6", "status after gap", status, 0);
        if (cap) begin
            prev_code = c;
        end else begin
            chk("R1", "rd_data kept for short tone", rd_data, prev_code);
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk("R8", "rd_data at reset", rd_data, 0);
        chk("R8", "status at reset", status, 0);
        chk("R8", "guard_out at reset", guard_out, 0);
        chk("R8", "irq_n at reset", irq_n, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: zero counts still run the full sequence.
        guard_on_ticks = 0; settle_ticks = 0; guard_off_ticks = 0;
        irq_mode = 1'b1; code_in = 4'h9;
        hold(1'b1, 2);
        chk("R8", "zero-count rd_data", rd_data, 9);
        chk("R8", "zero-count flag", dv_flag, 1);
        chk("R8", "zero-count irq_n", irq_n, 0);
        hold(1'b0, 2);
        chk("R8", "zero-count flag cleared", dv_flag, 0);
        prev_code = 4'h9;

        // R4: flag must wait for the settle count after capture.
        guard_on_ticks = 2; settle_ticks = 6; guard_off_ticks = 3;
        irq_mode = 1'b0; code_in = 4'h5;
        hold(1'b1, 5);
        chk("R4", "captured before settle done", rd_data, 5);
        chk("R4", "flag low during settle", dv_flag, 0);
        chk("R3", "guard_out during settle", guard_out, 1);
        hold(1'b1, 6);
        chk("R4", "flag after settle", dv_flag, 1);
        chk("R7", "irq_n in polled mode", irq_n, 1);
        chk("R7", "status bit1 in polled mode", status, 1);
        hold(1'b0, 6);
        prev_code = 4'h5;

        // R1: directed short tone with a new code.
        trial(4, 2, 3, 1'b1, 1'b0, 1'b0, 1'b0, 4'hC);

        // Random trials.
        for (int i = 0; i < 40; i++) begin
            int g, s, a;
            logic [3:0] c;
            g = 2 + int'($urandom % 5);
            s = int'($urandom % 5);
            a = 3 + int'($urandom % 5);
            c = prev_code + 4'(1 + ($urandom % 15));
            trial(g, s, a, 1'($urandom), ($urandom % 4) != 0,
                  1'($urandom), 1'($urandom), c);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule